// File: doc/BRIEF.md
# Vector Bitwise Select Unit

This block merges vector operands bit by bit under a mask, for a vector execution pipe that works on 128-bit and 256-bit registers. It offers two operations. The three-source merge takes a mask vector and two data vectors. Each result bit comes from one of the data vectors, chosen by the matching mask bit. The immediate merge takes the register's previous destination value as the mask. Where a mask bit is clear it passes the source vector, and where a mask bit is set it passes an 8-bit immediate that is copied into every byte lane.

An operation starts with a one-cycle `start` pulse that carries the operands, the operation select and the length select. The result is registered and appears with `out_valid` on the next cycle. With the short length, only the low 16 byte lanes are computed and the upper half of the result is forced to zero. A two-state controller sequences the strobe. In state IDLE nothing is pending. The transition IDLE->BUSY is taken on `start`. BUSY->BUSY is taken on a back-to-back `start`. BUSY->IDLE is taken when no `start` arrives. `out_valid` is high exactly in BUSY.

Top module: `vbit_select_unit`

## Requirements
- R1: With `op_imm`=0, each result bit equals `vec_hi` where `vec_mask` is 1 and `vec_lo` where `vec_mask` is 0.
- R2: With `op_imm`=1, each result byte equals (NOT m AND lo) OR (m AND imm8): `vec_lo` where the mask bit is 0 and the matching bit of `imm8` where it is 1. The same `imm8` applies to every byte lane.
- R3: With `op_imm`=1, `vec_hi` has no effect on the result.
- R4: With `wide`=1, all 256 result bits are computed from the operands.
- R5: With `wide`=0, result bits 127:0 are computed, bits 255:128 are zero, and operand bits 255:128 have no effect.
- R6: `out_valid` rises in the cycle after a `start` pulse, and `result` carries that operation's value in the same cycle.
- R7: When no `start` was given in the previous cycle, `out_valid` is 0. Back-to-back `start` pulses give back-to-back valid results.
- R8: `result` holds its last value while no operation is started.
- R9: During and after reset, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches an operation |
| op_imm | input | 1 | 0 selects the three-source merge, 1 selects the immediate merge |
| wide | input | 1 | 1 selects the 32-byte length, 0 selects the 16-byte length |
| vec_mask | input | 256 | Mask vector (previous destination in the immediate merge) |
| vec_lo | input | 256 | Data taken where the mask bit is 0 |
| vec_hi | input | 256 | Data taken where the mask bit is 1 (three-source merge only) |
| imm8 | input | 8 | Immediate copied into every byte lane |
| out_valid | output | 1 | Result strobe, high one cycle after `start` |
| result | output | 256 | Registered result vector |

## Verification
Every result is due exactly one rising edge after the edge that samples its `start`. The driver applies each operation just after a falling edge and pushes the reference value into a queue. The monitor samples one nanosecond after each rising edge. It pops and compares whenever `out_valid` is high, and it reports a missing or unexpected strobe, so a late or early result is a mismatch. While no strobe is present, the monitor checks that `result` still holds the last expected value.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned FULL_LANES = 32;
    localparam int unsigned HALF_LANES = 16;
    localparam int unsigned VEC_W      = FULL_LANES * BYTE_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } vbs_state_e;

    typedef enum logic {
        OP_THREE_SRC = 1'b0,
        OP_IMM_MERGE = 1'b1
    } vbs_op_e;
endpackage

// File: rtl/vbs_lane.sv
module vbs_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              enable,
    input  logic              op_imm,
    input  logic [LANE_W-1:0] m,
    input  logic [LANE_W-1:0] lo,
    input  logic [LANE_W-1:0] hi,
    input  logic [LANE_W-1:0] imm,
    output logic [LANE_W-1:0] y
);
    logic [LANE_W-1:0] set_src;

    always_comb begin
        set_src = (op_imm == vbs_pkg::OP_IMM_MERGE) ? imm : hi;
        if (enable) begin
            y = (~m & lo) | (m & set_src);
        end else begin
            y = '0;
        end
    end

    always_comb begin
        if (enable && (m == '0)) begin
            a_r1_clear_mask_passes_lo : assert (y == lo);
        end
        if (!enable) begin
            a_r5_disabled_lane_zero : assert (y == '0);
        end
    end
endmodule

// File: rtl/vbs_datapath.sv
module vbs_datapath #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned HALF   = 16,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned W     = LANES * LANE_W
) (
    input  logic              op_imm,
    input  logic              wide,
    input  logic [W-1:0]      vec_mask,
    input  logic [W-1:0]      vec_lo,
    input  logic [W-1:0]      vec_hi,
    input  logic [LANE_W-1:0] imm,
    output logic [W-1:0]      y
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_en;
        if (g < HALF) begin : g_low
            assign lane_en = 1'b1;
        end else begin : g_high
            assign lane_en = wide;
        end
        vbs_lane #(.LANE_W(LANE_W)) u_lane (
            .enable (lane_en),
            .op_imm (op_imm),
            .m      (vec_mask[g*LANE_W +: LANE_W]),
            .lo     (vec_lo[g*LANE_W +: LANE_W]),
            .hi     (vec_hi[g*LANE_W +: LANE_W]),
            .imm    (imm),
            .y      (y[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/vbs_ctrl.sv
module vbs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic valid
);
    import vbs_pkg::*;

    vbs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_BUSY : ST_IDLE;
            ST_BUSY: state_d = start ? ST_BUSY : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load  = start;
        valid = 1'b0;
        unique case (state_q)
            ST_IDLE: valid = 1'b0;
            ST_BUSY: valid = 1'b1;
            default: valid = 1'b0;
        endcase
    end

    a_r6_valid_after_start : assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    a_r7_no_valid_without_start : assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
endmodule

// File: rtl/vbit_select_unit.sv
module vbit_select_unit #(
    parameter int unsigned LANES  = vbs_pkg::FULL_LANES,
    parameter int unsigned HALF   = vbs_pkg::HALF_LANES,
    parameter int unsigned LANE_W = vbs_pkg::BYTE_W,
    localparam int unsigned W     = LANES * LANE_W,
    localparam int unsigned HW    = HALF * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_imm,
    input  logic              wide,
    input  logic [W-1:0]      vec_mask,
    input  logic [W-1:0]      vec_lo,
    input  logic [W-1:0]      vec_hi,
    input  logic [LANE_W-1:0] imm8,
    output logic              out_valid,
    output logic [W-1:0]      result
);
    logic         load;
    logic [W-1:0] comb_y;

    vbs_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .valid (out_valid)
    );

    vbs_datapath #(.LANES(LANES), .HALF(HALF), .LANE_W(LANE_W)) u_dp (
        .op_imm   (op_imm),
        .wide     (wide),
        .vec_mask (vec_mask),
        .vec_lo   (vec_lo),
        .vec_hi   (vec_hi),
        .imm      (imm8),
        .y        (comb_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load) begin
            result <= comb_y;
        end
    end

    a_r5_upper_zero_short : assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wide) |=> (result[W-1:HW] == '0));
    a_r8_hold_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));
    a_r9_reset_clears : assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

// File: tb/tb_vbit_select_unit.sv
module tb_vbit_select_unit;
    localparam int W = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_imm = 1'b0;
    logic         wide = 1'b0;
    logic [W-1:0] vec_mask = '0;
    logic [W-1:0] vec_lo = '0;
    logic [W-1:0] vec_hi = '0;
    logic [7:0]   imm8 = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    typedef struct {
        logic [W-1:0] val;
        string        req;
    } exp_t;
    exp_t         sb_q[$];
    logic [W-1:0] last_exp = '0;

    always #2 clk = ~clk;

    vbit_select_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_imm(op_imm), .wide(wide),
        .vec_mask(vec_mask), .vec_lo(vec_lo), .vec_hi(vec_hi), .imm8(imm8),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [W-1:0] ref_model(input logic op, input logic w,
        input logic [W-1:0] m, input logic [W-1:0] lo, input logic [W-1:0] hi,
        input logic [7:0] im);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            logic setv;
            setv = op ? im[i % 8] : hi[i];
            if (!w && i >= 128) r[i] = 1'b0;
            else r[i] = m[i] ? setv : lo[i];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd256();
        logic [W-1:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: applies one operation after a falling edge and queues its reference value.
    task automatic drive(input string req, input logic op, input logic w,
        input logic [W-1:0] m, input logic [W-1:0] lo, input logic [W-1:0] hi,
        input logic [7:0] im);
        exp_t e;
        @(negedge clk);
        start = 1'b1; op_imm = op; wide = w;
        vec_mask = m; vec_lo = lo; vec_hi = hi; imm8 = im;
        e.val = ref_model(op, w, m, lo, hi, im);
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start = 1'b0;
            vec_mask = rnd256(); vec_lo = rnd256(); vec_hi = rnd256(); imm8 = 8'($urandom);
        end
    endtask

    // Monitor: samples 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en) begin
                if (out_valid) begin
                    if (sb_q.size() == 0) begin
                        tests++; fails++;
                        $display("FAIL R7 actual=valid expected=no valid");
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(e.req, result, e.val);
                        last_exp = e.val;
                    end
                end else begin
                    if (sb_q.size() != 0) begin
                        tests++; fails++;
                        $display("FAIL R6 actual=no valid expected=valid");
                        void'(sb_q.pop_front());
                    end
                    check("R8 hold", result, last_exp);
                end
            end
        end
    end

    initial begin
        logic [W-1:0] m, lo, hi;
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || result !== '0) begin
            fails++;
            $display("FAIL R9 actual=%b/%h expected=0/0", out_valid, result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // R1: directed three-source merges
        drive("R1 all-ones mask", 1'b0, 1'b1, '1, rnd256(), {8{32'hA5A5_5A5A}}, 8'h00);
        drive("R1 zero mask", 1'b0, 1'b1, '0, {8{32'h1234_5678}}, rnd256(), 8'hFF);
        drive("R1 alternating", 1'b0, 1'b1, {64{4'hA}}, '0, '1, 8'h00);
        idle(2);
        // R2: immediate merge, every byte uses the same imm
        drive("R2 full mask gives imm", 1'b1, 1'b1, '1, rnd256(), rnd256(), 8'h3C);
        drive("R2 zero mask gives lo", 1'b1, 1'b1, '0, {8{32'hDEAD_BEEF}}, rnd256(), 8'hC3);
        // R3: vec_hi differs, results must match the same reference
        m = rnd256(); lo = rnd256();
        drive("R3 hi ignored a", 1'b1, 1'b1, m, lo, '0, 8'h96);
        drive("R3 hi ignored b", 1'b1, 1'b1, m, lo, '1, 8'h96);
        idle(1);
        // R5: short length, upper operands all ones
        drive("R5 short three-source", 1'b0, 1'b0, '1, '1, '1, 8'hFF);
        drive("R5 short imm", 1'b1, 1'b0, '1, '1, '1, 8'hFF);
        idle(3);
        // R4/R5/R1/R2 random, mixed back-to-back (R7) and gaps (R8)
        for (int n = 0; n < 400; n++) begin
            logic op, w;
            op = 1'($urandom); w = 1'($urandom);
            m = rnd256(); lo = rnd256(); hi = rnd256();
            drive(w ? (op ? "R4 R2 random wide" : "R4 R1 random wide")
                    : (op ? "R5 R2 random short" : "R5 R1 random short"),
                  op, w, m, lo, hi, 8'($urandom));
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(3);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule